// File: doc/BRIEF.md
# Printer Port Register File with Internal Handshake

This block is the host-facing register set of a byte-wide compatibility-mode printer port. A small bus with separate read and write strobes reaches a data write latch, a data read latch, a status register and a control register. There are no pin drivers. The printer side is modelled inside the block: software that writes the control register sees busy, acknowledge and the interrupt respond the way a real printer would make them respond. A byte that software strobes out leaves on a valid/ready stream toward a printer sink.

Software first places a byte in the data register. It then drives the strobe control bit from 0 to 1 with select and initialise held high. That emits the byte and clears busy. While strobe is low, each status poll steps the acknowledge/busy sequence forward. If software drops strobe while interrupts are enabled, an interrupt becomes pending. The next status read clears it.

Top module: `prn_port_regs`

## Requirements
- R1: Only the low three address bits select a register; higher address bits are ignored. Offset 0 is data, offset 1 is status, offset 2 is control, and a read at any of offsets 3 to 7 returns 0xFF.
- R2: After reset the write latch and the read latch both hold 0xFF, status is 0xD9, control is 0xCC, the interrupt output is 0 and the stream output is not valid.
- R3: Control bits 7 and 6 always read back as 1, whatever value was written to them.
- R4: A control write whose bit 2 (initialise) is 0 loads status with 0xD8: bit 7 busy, bit 6 acknowledge, bit 4 online and bit 3 error all set.
- R5: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7 (busy). If the stored strobe bit was 0, the same write emits the write-latch byte on the stream exactly once.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the interrupt output from the next cycle, provided the previously stored control bit 4 (interrupt enable) was 1.
- R7: A status read returns the status value held before the read, and the interrupt output is 0 from the next cycle.
- R8: When a status read finds status bit 7 = 0 and the stored strobe bit = 0, it clears bit 6 if bit 6 was 1. Otherwise, under the same condition, it sets both bit 6 and bit 7. Under any other condition the read leaves status unchanged.
- R9: A data read returns the read latch when control bit 5 (direction) is 1, and the write latch when it is 0.
- R10: An emitted byte stays valid with stable data until the sink accepts it. A new emission made while the stream holds a byte not yet accepted is discarded.
- R11: Writes at offset 1 and at offsets 3 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address; only the low 3 bits decode |
| bus_wr | input | 1 | Write strobe; writes take effect at the clock edge |
| bus_rd | input | 1 | Read strobe; read side effects occur at the clock edge and are ignored when bus_wr is also high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| irq | output | 1 | Interrupt pending |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |

## Verification
The embedded assertions are checked on every cycle:
- control reads always show bits 7 and 6 set, and a read at offsets 3 to 7 returns 0xFF;
- initialise low forces status to 0xD8, and a strobe-high write with select clears busy;
- a status read always removes the interrupt;
- a stalled stream byte holds its value until accepted.

Some behaviour needs the bench's stateful scenarios instead. These are the exact two-step acknowledge/busy sequence over repeated polls, the dependence of the interrupt on the previously stored enable bit, the once-only emission on a strobe rising edge, the direction-dependent data read, and the dropping of a second byte while the sink stalls. The bench covers them with a sweep over every control value, run against an arithmetic model.

// File: rtl/prn_pkg.sv
package prn_pkg;

  localparam int BYTE_W = 8;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_BUSY_N = 7;
  localparam int ST_ACK    = 6;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] CTRL_FIXED  = 8'hC0;
  localparam logic [BYTE_W-1:0] STAT_RESET  = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INITLO = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RESET  = 8'hCC;
  localparam logic [BYTE_W-1:0] LATCH_RESET = 8'hFF;
  localparam logic [BYTE_W-1:0] HOLE_VALUE  = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_stat;
  } prn_acc_t;

endpackage

// File: rtl/prn_decode.sv
module prn_decode
  import prn_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [2:0]        ofs,
  output prn_acc_t          acc
);

  generate
    if (ADDR_W > 3) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:3];
    end
  endgenerate

  assign ofs = addr[2:0];

  always_comb begin
    acc.wr_data = wr && (ofs == OFS_DATA);
    acc.wr_ctrl = wr && (ofs == OFS_CTRL);
    acc.rd_stat = rd && !wr && (ofs == OFS_STAT);
  end

endmodule

// File: rtl/prn_ctlstat.sv
module prn_ctlstat
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              irq_o,
  output logic              emit_o
);

  logic [BYTE_W-1:0] ctrl_q, ctrl_nx, stat_q, stat_nx, wv;
  logic              pend_q, pend_nx;

  always_comb begin
    ctrl_nx = ctrl_q;
    stat_nx = stat_q;
    pend_nx = pend_q;
    emit_o  = 1'b0;
    wv      = wdata | CTRL_FIXED;
    if (wr_ctrl) begin
      ctrl_nx = wv;
      if (!wv[CT_INIT]) begin
        stat_nx = STAT_INITLO;
      end else if (wv[CT_SEL]) begin
        if (wv[CT_STB]) begin
          stat_nx[ST_BUSY_N] = 1'b0;
          emit_o = !ctrl_q[CT_STB];
        end else if (ctrl_q[CT_IEN]) begin
          pend_nx = 1'b1;
        end
      end
    end
    if (rd_stat) begin
      pend_nx = 1'b0;
      if (!stat_q[ST_BUSY_N] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_nx[ST_ACK] = 1'b0;
        end else begin
          stat_nx[ST_ACK]    = 1'b1;
          stat_nx[ST_BUSY_N] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      stat_q <= STAT_RESET;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl)            ctrl_q <= ctrl_nx;
      if (wr_ctrl || rd_stat) stat_q <= stat_nx;
      if (wr_ctrl || rd_stat) pend_q <= pend_nx;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = stat_q;
  assign irq_o    = pend_q;

  AST_INIT_FORCES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CT_INIT]) |=> (status_o == STAT_INITLO)); // R4

  AST_STROBE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB]) |=> !status_o[ST_BUSY_N]); // R5

  AST_STATUS_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !irq_o); // R7

endmodule

// File: rtl/prn_emit.sv
module prn_emit
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit_req,
  input  logic [BYTE_W-1:0] emit_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);

  logic              vld_q, vld_nx, load;
  logic [BYTE_W-1:0] dat_q;

  always_comb begin
    load   = emit_req && (!vld_q || out_ready);
    vld_nx = vld_q;
    if (vld_q && out_ready) vld_nx = 1'b0;
    if (load)               vld_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_nx;
      if (load) dat_q <= emit_byte;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  AST_STALL_HOLDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);

  prn_acc_t          acc;
  logic [2:0]        ofs;
  logic [BYTE_W-1:0] wlat_q, wlat_nx, rlat_q, ctrl, status;
  logic              emit;

  prn_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .ofs  (ofs),
    .acc  (acc)
  );

  prn_ctlstat u_cs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (acc.wr_ctrl),
    .rd_stat  (acc.rd_stat),
    .wdata    (bus_wdata),
    .ctrl_o   (ctrl),
    .status_o (status),
    .irq_o    (irq),
    .emit_o   (emit)
  );

  prn_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit_req  (emit),
    .emit_byte (wlat_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  assign wlat_nx = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlat_q <= LATCH_RESET;
      rlat_q <= LATCH_RESET;
    end else begin
      if (acc.wr_data) wlat_q <= wlat_nx;
      rlat_q <= rlat_q;
    end
  end

  always_comb begin
    case (ofs)
      OFS_DATA: bus_rdata = ctrl[CT_DIR] ? rlat_q : wlat_q;
      OFS_STAT: bus_rdata = status;
      OFS_CTRL: bus_rdata = ctrl;
      default:  bus_rdata = HOLE_VALUE;
    endcase
  end

  AST_CTRL_TOP_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:0] == OFS_CTRL) |-> (bus_rdata[7:6] == 2'b11)); // R3

  AST_HOLE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:0] > OFS_CTRL) |-> (bus_rdata == 8'hFF)); // R1

endmodule

// File: tb/prn_port_regs_test.sv
`timescale 1ns/1ps
module prn_port_regs_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_wr, bus_rd, out_ready;
  logic [7:0] bus_wdata, bus_rdata, out_data;
  logic       irq, out_valid;

  int n_vec = 0, n_bad = 0;
  int acc_cnt = 0;
  logic [7:0] acc_byte = 8'h00;
  bit done = 0;

  // reference model state
  logic [7:0] m_dw, m_dr, m_st, m_ct;
  logic       m_irq;
  int         m_emit;
  logic [7:0] m_last;

  always #5 clk = ~clk;

  prn_port_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always @(posedge clk)
    if (rst_n && out_valid && out_ready) begin
      acc_cnt  = acc_cnt + 1;
      acc_byte = out_data;
    end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic m_ctrl(input logic [7:0] v);
    logic [7:0] val;
    val = v | 8'hC0;
    if (!val[2]) m_st = 8'hD8;
    else if (val[3]) begin
      if (val[0]) begin
        m_st[7] = 1'b0;
        if (!m_ct[0]) begin m_emit++; m_last = m_dw; end
      end else if (m_ct[4]) m_irq = 1'b1;
    end
    m_ct = val;
  endtask

  task automatic m_stat(output logic [7:0] r);
    r = m_st;
    m_irq = 1'b0;
    if (!m_st[7] && !m_ct[0]) begin
      if (m_st[6]) m_st[6] = 1'b0;
      else m_st[7:6] = 2'b11;
    end
  endtask

  task automatic check_read(input logic [3:0] a, input string req);
    logic [7:0] got, exp;
    case (a[2:0])
      3'd0: exp = m_ct[5] ? m_dr : m_dw;
      3'd1: m_stat(exp);
      3'd2: exp = m_ct;
      default: exp = 8'hFF;
    endcase
    rd(a, got);
    chk(req, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_irq = 0; m_emit = 0; m_last = 0;

    // R2 reset state
    @(negedge clk);
    chk("R2 irq", irq, 0);
    chk("R2 out_valid", out_valid, 0);
    rd(4'd2, got); chk("R2 control", got, 8'hCC);
    rd(4'd0, got); chk("R2 write latch", got, 8'hFF);
    rd(4'd1, got); chk("R2 status", got, 8'hD9); m_stat(got);
    wr(4'd2, 8'h2C); m_ctrl(8'h2C);
    rd(4'd0, got); chk("R2 read latch", got, 8'hFF);
    wr(4'd2, 8'h0C); m_ctrl(8'h0C);

    // R1 address sweep incl. upper bit aliasing
    wr(4'd0, 8'h96); m_dw = 8'h96;
    for (int a = 0; a < 16; a++) check_read(a[3:0], "R1 decode");

    // R11 writes to status and holes leave registers unchanged
    for (int a = 0; a < 16; a++) begin
      if (a[2:0] != 3'd0 && a[2:0] != 3'd2) begin
        wr(a[3:0], 8'(a * 37 + 1));
        check_read(4'd0, "R11 data");
        check_read(4'd2, "R11 control");
        check_read(4'd1, "R11 status");
      end
    end

    // R8 explicit handshake sequence
    wr(4'd2, 8'h0D); m_ctrl(8'h0D);
    wr(4'd2, 8'h0C); m_ctrl(8'h0C);
    rd(4'd1, got); chk("R8 first poll", got, 8'h59); m_stat(got);
    rd(4'd1, got); chk("R8 ack cleared", got, 8'h19); m_stat(got);
    rd(4'd1, got); chk("R8 busy+ack set", got, 8'hD9); m_stat(got);
    rd(4'd1, got); chk("R8 stays", got, 8'hD9); m_stat(got);

    // main sweep over every control value (R3 R4 R5 R6 R7 R9)
    for (int v = 0; v < 256; v++) begin
      wr(4'd0, 8'(v) ^ 8'h3C); m_dw = 8'(v) ^ 8'h3C;
      wr(4'd2, 8'(v)); m_ctrl(8'(v));
      chk("R6 irq after control write", irq, m_irq);
      check_read(4'd2, "R3 control readback");
      check_read(4'd0, "R9 data direction");
      check_read(4'd1, "R4 R8 status");
      chk("R7 irq cleared by status read", irq, 0);
      chk("R5 emit count", acc_cnt, m_emit);
      chk("R5 emitted byte", acc_byte, m_last);
    end

    // R10 stall: hold then drop
    out_ready = 1'b0;
    wr(4'd0, 8'hA5);
    wr(4'd2, 8'h0C);
    wr(4'd2, 8'h0D);
    repeat (5) @(negedge clk);
    chk("R10 held valid", out_valid, 1);
    chk("R10 held data", out_data, 8'hA5);
    wr(4'd0, 8'h3C);
    wr(4'd2, 8'h0C);
    wr(4'd2, 8'h0D);
    repeat (2) @(negedge clk);
    chk("R10 second byte dropped", out_data, 8'hA5);
    chk("R10 nothing accepted", acc_cnt, m_emit);
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 one accepted", acc_cnt, m_emit + 1);
    chk("R10 accepted byte", acc_byte, 8'hA5);
    chk("R10 stream empty", out_valid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule